// File: doc/BRIEF.md
# Synthesizer Divider Programming Register

This block holds the control word for a frequency synthesizer: a 9-bit feedback divide value (M), a 2-bit output divide value (N) and a 2-bit test selector. The word can be written from a parallel bus or from a three-wire serial port. On the parallel path, the M and N buses follow straight into the active word while the active-low parallel strobe is low, and the word freezes when that strobe rises. On the serial path, a 14-slot frame is clocked in on the serial clock and then committed while the serial strobe is high. The test selector picks what drives a diagnostic pin.

All strobes, the serial clock and the serial data are asynchronous. They pass through two-flop synchronizers into the one system clock, and every edge is detected in that domain. A change on a pin shows up on the outputs within five system clock cycles. The serial clock must therefore run well below the system clock. A status output flags any active M value outside the range over which the loop can lock.

Top module: `synth_cfg_reg`

## Requirements
- R1: While `rst` is high, `test_bits` clears to 00, `test_out` and `sr` state clear, and `m_val`/`n_val` load the values present on `par_m`/`par_n`.
- R2: While `par_load_n` is low, `m_val` and `n_val` follow `par_m` and `par_n`, and `test_bits` is held at 00.
- R3: When `par_load_n` rises, the last bus values are kept. Later changes on `par_m`/`par_n` have no effect while `par_load_n` stays high and `ser_load` stays low.
- R4: With `par_load_n` high, each rising edge of `ser_clk` shifts `ser_data` into the shift register. While `ser_load` is low, shifting does not change `m_val`, `n_val` or `test_bits`.
- R5: While `ser_load` is high (and `par_load_n` high), the shift register content is copied to the active word. When `ser_load` falls, the word is held.
- R6: With `ser_load` held high, every rising edge of `ser_clk` moves the newly shifted register content onto the outputs.
- R7: The serial frame is 14 bits, sent first to last as: test bit 1, test bit 0, one ignored slot, N bit 1, N bit 0, then M bit 8 down to M bit 0. The value in the ignored slot changes nothing.
- R8: With `par_load_n` high, `test_out` is set by `test_bits`: 00 gives 0, 01 gives the synchronized `ser_data`, 10 gives `fb_div_in`, and 11 gives `cmos_clk_in`.
- R9: While `par_load_n` is low, `test_out` is 0 whatever the test bits were before.
- R10: `m_range_err` is 1 exactly when `m_val` is below 8 or above 28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load_n | input | 1 | Parallel strobe, low = transparent, rising edge latches |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide value |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on `ser_clk` rise |
| ser_load | input | 1 | Serial commit strobe, high = transparent |
| fb_div_in | input | 1 | Feedback divider output, test source |
| cmos_clk_in | input | 1 | CMOS output clock, test source |
| m_val | output | 9 | Active feedback divide value |
| n_val | output | 2 | Active output divide value |
| test_bits | output | 2 | Active test selector |
| test_out | output | 1 | Diagnostic output |
| m_range_err | output | 1 | Active M outside the lockable range |

## Verification
The assertions assume that `par_m` and `par_n` are stable around a `par_load_n` rise. They also assume that every pin level lasts at least two system cycles, so the synchronizers never miss an edge. The stimulus changes only one asynchronous pin at a time. It holds each serial clock phase for four system cycles and keeps the buses still for six cycles around each strobe edge. `ser_load` is kept low whenever `par_load_n` rises, so a parallel latch never meets a pending serial transfer.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int M_W = 9;
  localparam int N_W = 2;
  localparam int T_W = 2;
  // ignored slot sits between the N field and the test field
  localparam int NULL_POS = M_W + N_W;
  localparam int FRAME_W  = T_W + 1 + N_W + M_W;
  localparam int WORD_W   = FRAME_W - 1;

  typedef enum logic [1:0] {
    TSEL_LOW   = 2'b00,
    TSEL_SDATA = 2'b01,
    TSEL_FBDIV = 2'b10,
    TSEL_CMOS  = 2'b11
  } tsel_e;

  typedef struct packed {
    logic [T_W-1:0] t;
    logic [N_W-1:0] n;
    logic [M_W-1:0] m;
  } cfg_word_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
  parameter int W   = 14,
  parameter int GAP = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-2:0] payload
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)     sr <= '0;
    else if (en) sr <= {sr[W-2:0], din};
  end

  // drop the ignored slot from the word handed upward
  assign payload = {sr[W-1:GAP+1], sr[GAP-1:0]};

  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(sr));
  // R4
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> (sr[0] == $past(din)));
endmodule

// File: rtl/cfg_testsel.sv
module cfg_testsel
  import synth_cfg_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           par_mode,
  input  logic [T_W-1:0] tsel,
  input  logic           src_sdata,
  input  logic           src_fb,
  input  logic           src_cmos,
  output logic           test_out
);
  logic pick;

  always_comb begin
    unique case (tsel_e'(tsel))
      TSEL_LOW:   pick = 1'b0;
      TSEL_SDATA: pick = src_sdata;
      TSEL_FBDIV: pick = src_fb;
      TSEL_CMOS:  pick = src_cmos;
      default:    pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) test_out <= 1'b0;
    else     test_out <= par_mode ? 1'b0 : pick;
  end

  // R9
  par_low_chk: assert property (@(posedge clk) disable iff (rst)
    par_mode |=> !test_out);
  // R8
  sel_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && tsel == 2'b00) |=> !test_out);
  // R8
  sel_cmos_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_mode && tsel == 2'b11) |=> (test_out == $past(src_cmos)));
endmodule

// File: rtl/synth_cfg_reg.sv
module synth_cfg_reg
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int M_LO        = 8,
  parameter int M_HI        = 28
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_load,
  input  logic           fb_div_in,
  input  logic           cmos_clk_in,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_val,
  output logic [T_W-1:0] test_bits,
  output logic           test_out,
  output logic           m_range_err
);
  localparam logic [M_W-1:0] LO_V = M_LO[M_W-1:0];
  localparam logic [M_W-1:0] HI_V = M_HI[M_W-1:0];

  logic [3:0] pins_s;
  logic pl_s, sc_s, sd_s, sl_s, sc_d, sc_rise;
  logic [WORD_W-1:0] ser_word;
  cfg_word_t cur_q, nxt, par_word;

  cfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_sync (
    .clk(clk), .rst(rst),
    .d({par_load_n, ser_clk, ser_data, ser_load}),
    .q(pins_s)
  );
  assign {pl_s, sc_s, sd_s, sl_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sc_d <= 1'b0;
    else     sc_d <= sc_s;
  end
  assign sc_rise = sc_s & ~sc_d;

  cfg_shift #(.W(FRAME_W), .GAP(NULL_POS)) u_shift (
    .clk(clk), .rst(rst), .en(pl_s & sc_rise), .din(sd_s),
    .payload(ser_word)
  );

  assign par_word = '{t: '0, n: par_n, m: par_m};

  always_comb begin
    nxt = cur_q;
    if (!pl_s)     nxt = par_word;
    else if (sl_s) nxt = cfg_word_t'(ser_word);
  end

  function automatic logic out_of_range(input logic [M_W-1:0] mv);
    return (mv < LO_V) || (mv > HI_V);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= par_word;
      m_range_err <= out_of_range(par_m);
    end else begin
      cur_q       <= nxt;
      m_range_err <= out_of_range(nxt.m);
    end
  end

  assign m_val     = cur_q.m;
  assign n_val     = cur_q.n;
  assign test_bits = cur_q.t;

  cfg_testsel u_tsel (
    .clk(clk), .rst(rst), .par_mode(!pl_s), .tsel(cur_q.t),
    .src_sdata(sd_s), .src_fb(fb_div_in), .src_cmos(cmos_clk_in),
    .test_out(test_out)
  );

  // R2
  par_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !pl_s |=> (m_val == $past(par_m) && n_val == $past(par_n) && test_bits == '0));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pl_s && !sl_s) |=> $stable(cur_q));
  // R10
  range_chk: assert property (@(posedge clk) disable iff (rst)
    m_range_err == ((m_val < LO_V) || (m_val > HI_V)));
endmodule

// File: tb/synth_cfg_reg_tb.sv
module synth_cfg_reg_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic par_load_n, ser_clk, ser_data, ser_load, fb_div_in, cmos_clk_in;
  logic [8:0] par_m;
  logic [1:0] par_n;
  logic [8:0] m_val;
  logic [1:0] n_val, test_bits;
  logic test_out, m_range_err;

  always #10 clk = ~clk;

  synth_cfg_reg dut_i (
    .clk(clk), .rst(rst), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_load(ser_load),
    .fb_div_in(fb_div_in), .cmos_clk_in(cmos_clk_in),
    .m_val(m_val), .n_val(n_val), .test_bits(test_bits),
    .test_out(test_out), .m_range_err(m_range_err)
  );

  typedef struct {
    logic [8:0] m;
    logic [1:0] n;
    logic [1:0] t;
    logic       to;
    logic       err;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [13:0] sr_model = '0;

  task automatic wcyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic [8:0] m, input logic [1:0] n,
                            input logic [1:0] t, input logic to, input string tag);
    item_t it;
    it.m = m; it.n = n; it.t = t; it.to = to;
    it.err = (m < 9'd8) || (m > 9'd28);
    it.tag = tag;
    exp_q.push_back(it);
    wcyc(2);
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    wcyc(4);
    ser_clk = 1'b1;
    wcyc(4);
    ser_clk = 1'b0;
    sr_model = {sr_model[12:0], b};
  endtask

  task automatic shift_frame(input logic [1:0] t, input logic nb,
                             input logic [1:0] n, input logic [8:0] m);
    logic [13:0] f;
    f = {t, nb, n, m};
    for (int i = 13; i >= 0; i--) shift_bit(f[i]);
    ser_data = 1'b0;
    wcyc(6);
  endtask

  task automatic load_pulse();
    ser_load = 1'b1;
    wcyc(6);
    ser_load = 1'b0;
    wcyc(6);
  endtask

  // monitor: compare queued expectations against the outputs at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        checks++;
        if (m_val !== it.m || n_val !== it.n || test_bits !== it.t ||
            test_out !== it.to || m_range_err !== it.err) begin
          errors++;
          $display("FAIL %s: actual m=%0d n=%0d t=%b to=%b err=%b expected m=%0d n=%0d t=%b to=%b err=%b",
                   it.tag, m_val, n_val, test_bits, test_out, m_range_err,
                   it.m, it.n, it.t, it.to, it.err);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; par_load_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0;
    fb_div_in = 1'b0; cmos_clk_in = 1'b0; par_m = 9'd20; par_n = 2'd1;
    wcyc(5);
    rst = 1'b0;
    expect_out(9'd20, 2'd1, 2'b00, 1'b0, "R1 reset");

    // R2 transparent parallel path, also out-of-range flag (R10)
    par_m = 9'd5; par_n = 2'd2;
    wcyc(6);
    expect_out(9'd5, 2'd2, 2'b00, 1'b0, "R2 follow / R10 low");

    // R3 latch on strobe rise, later bus changes ignored
    par_m = 9'd12; par_n = 2'd3;
    wcyc(6);
    par_load_n = 1'b1;
    wcyc(6);
    par_m = 9'd100; par_n = 2'd0;
    wcyc(6);
    expect_out(9'd12, 2'd3, 2'b00, 1'b0, "R3 latched");

    // R4 shifting with commit strobe low leaves outputs alone
    shift_frame(2'b01, 1'b0, 2'd2, 9'd25);
    expect_out(9'd12, 2'd3, 2'b00, 1'b0, "R4 shift no effect");

    // R5 commit, R7 field order
    load_pulse();
    expect_out(9'd25, 2'd2, 2'b01, 1'b0, "R5 commit / R7 order");
    // R8 select 01 routes serial data
    ser_data = 1'b1;
    wcyc(6);
    expect_out(9'd25, 2'd2, 2'b01, 1'b1, "R8 sdata high");
    ser_data = 1'b0;
    wcyc(6);
    expect_out(9'd25, 2'd2, 2'b01, 1'b0, "R8 sdata low");

    // R8 select 10 routes divider output
    shift_frame(2'b10, 1'b0, 2'd0, 9'd9);
    load_pulse();
    fb_div_in = 1'b1;
    wcyc(6);
    expect_out(9'd9, 2'd0, 2'b10, 1'b1, "R8 fbdiv high");
    fb_div_in = 1'b0;
    wcyc(6);
    expect_out(9'd9, 2'd0, 2'b10, 1'b0, "R8 fbdiv low");

    // R8 select 11 routes CMOS clock
    cmos_clk_in = 1'b1;
    shift_frame(2'b11, 1'b0, 2'd1, 9'd28);
    load_pulse();
    expect_out(9'd28, 2'd1, 2'b11, 1'b1, "R8 cmos");

    // R7 ignored slot set to 1 gives identical word
    shift_frame(2'b11, 1'b1, 2'd1, 9'd28);
    load_pulse();
    expect_out(9'd28, 2'd1, 2'b11, 1'b1, "R7 null slot ignored");

    // R8 select 00 drives low, R10 above range
    shift_frame(2'b00, 1'b0, 2'd3, 9'd29);
    load_pulse();
    expect_out(9'd29, 2'd3, 2'b00, 1'b0, "R8 sel00 / R10 high");

    // R6 strobe held high: each serial clock updates outputs
    ser_load = 1'b1;
    wcyc(6);
    shift_bit(1'b1);
    ser_data = 1'b0;
    wcyc(6);
    expect_out(sr_model[8:0], sr_model[10:9], sr_model[13:12],
               (sr_model[13:12] == 2'b11) ? 1'b1 : 1'b0, "R6 passthrough bit1");
    shift_bit(1'b0);
    wcyc(6);
    expect_out(sr_model[8:0], sr_model[10:9], sr_model[13:12],
               (sr_model[13:12] == 2'b11) ? 1'b1 : 1'b0, "R6 passthrough bit0");
    ser_load = 1'b0;
    wcyc(6);

    // R9 parallel mode forces test output low
    shift_frame(2'b11, 1'b0, 2'd0, 9'd8);
    load_pulse();
    expect_out(9'd8, 2'd0, 2'b11, 1'b1, "R9 pre serial cmos");
    par_m = 9'd7; par_n = 2'd1;
    wcyc(6);
    par_load_n = 1'b0;
    wcyc(6);
    expect_out(9'd7, 2'd1, 2'b00, 1'b0, "R9 parallel low / R10 below");

    // R10 boundaries
    par_m = 9'd8;
    wcyc(6);
    expect_out(9'd8, 2'd1, 2'b00, 1'b0, "R10 at 8");
    par_m = 9'd28;
    wcyc(6);
    expect_out(9'd28, 2'd1, 2'b00, 1'b0, "R10 at 28");
    par_m = 9'd29;
    wcyc(6);
    expect_out(9'd29, 2'd1, 2'b00, 1'b0, "R10 at 29");

    wcyc(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule